// File: doc/BRIEF.md
# Command-Driven Wishbone Classic Master

This block takes simple commands from a processor-side port and runs them as Wishbone classic bus cycles to one external slave. Each command has a 3-bit opcode, an address, a write word and a word count. A command is accepted on a valid/ready handshake. The block can write or read one word or a run of words at consecutive addresses. It can also issue posted writes, which do not wait for the acknowledge, and it can drive a reset pulse to the slave.

The block keeps two separate "last address" registers, one for writes and one for reads. A continuing command starts one location past the last word of its kind, so software can stream data without sending addresses. For a multi-word write, the block pulls each write word from `cmd_wdata` through the `word_take` strobe. Read words come back one at a time on `rd_data`, each qualified by `rd_valid`.

When a width parameter is zero, the matching bus signals stay one bit wide and are driven low. Any input on the zero-width side is ignored.

Top module: `wb_cmd_master`

## Requirements
- R1: After `rst_n` is released, `wb_cyc_o`, `wb_stb_o`, `wb_rst_o`, `rd_valid` and `word_take` are low and `cmd_ready` is high. Both remembered addresses are all ones, so the first continuing read or write uses address 0.
- R2: Opcodes, and the count rule:
  - Code 0 is the reset pulse.
  - Code 1 writes at `cmd_addr`. Code 2 writes continuing.
  - Code 3 reads at `cmd_addr`. Code 4 reads continuing.
  - Code 5 is a posted write at `cmd_addr`. Code 6 is a posted write continuing.
  - Code 7 is accepted and causes no bus activity and no address change.
  - `cmd_count` gives the number of words. A count of 0 means 1.
- R3: A continuing write (codes 2 and 6) starts at the last written address plus one. Waited and posted writes share this register. A continuing read starts at the last read address plus one and is not affected by writes.
- R4: An N-word write goes to N consecutive addresses. Word k is the k-th value of `cmd_wdata` that is consumed. A value is consumed on each clock edge where `word_take` is high, and the first value is consumed on the accepting edge.
- R5: In a waited cycle, `wb_cyc_o` and `wb_stb_o` stay high, with address and write data stable, until `wb_ack_i` is sampled high.
- R6: After a waited word is acknowledged, `wb_cyc_o` is low for at least one clock. For N waited words, `wb_cyc_o` rises exactly N times.
- R7: In a posted write, each word holds `wb_cyc_o`/`wb_stb_o` for exactly one clock. Words follow back to back at consecutive addresses, so `wb_cyc_o` is high for exactly N clocks. `wb_ack_i` has no effect.
- R8: `rd_valid` is high for exactly one clock, in the clock after `wb_ack_i` was sampled high in a read. `rd_data` then carries the `wb_dat_i` value from that acknowledge.
- R9: `cmd_ready` is never high while `wb_cyc_o` is high. It stays low until the whole command has finished.
  - A waited command with acknowledge latency L is busy for N*(L+2)+N-1 clocks.
  - A posted command is busy for N clocks.
- R10: A reset command raises `wb_rst_o` for exactly RST_CYCLES clocks, starting the clock after acceptance. During the pulse, `wb_cyc_o` and `cmd_ready` stay low. `cmd_ready` returns the clock after the pulse ends. Both remembered addresses are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_addr | input | ADDR_W | Start address for the explicit-address opcodes |
| cmd_wdata | input | DATA_OUT_W | Write word; held until consumed |
| cmd_count | input | CNT_W | Word count, 0 counts as 1 |
| word_take | output | 1 | cmd_wdata is consumed at this edge |
| rd_valid | output | 1 | One-clock strobe for a returned read word |
| rd_data | output | DATA_IN_W | Returned read word |
| wb_rst_o | output | 1 | Reset pulse to the slave |
| wb_adr_o | output | ADDR_W | Bus address |
| wb_dat_o | output | DATA_OUT_W | Bus write data |
| wb_we_o | output | 1 | Write enable |
| wb_dat_i | input | DATA_IN_W | Bus read data |
| wb_stb_o | output | 1 | Strobe |
| wb_ack_i | input | 1 | Slave acknowledge |
| wb_cyc_o | output | 1 | Cycle valid |

## Verification
Each result has a fixed due cycle:
- The first bus clock comes one clock after the accepting edge.
- `rd_valid` comes one clock after the acknowledged read clock.
- The reset pulse starts one clock after acceptance and lasts RST_CYCLES clocks.
- `cmd_ready` returns N clocks after a posted command, or N*(L+2)+N-1 clocks after a waited command with slave latency L.

The bench drives each command on a falling edge and counts the busy clocks on later falling edges. It compares that count with the formula. It checks each `rd_valid` against the acknowledge seen on the previous falling edge. Memory contents and returned words are checked only after `cmd_ready` is back and two spare clocks have passed.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

  typedef enum logic [2:0] {
    OP_PULSE_RST = 3'd0,
    OP_WR_AT     = 3'd1,
    OP_WR_ON     = 3'd2,
    OP_RD_AT     = 3'd3,
    OP_RD_ON     = 3'd4,
    OP_PW_AT     = 3'd5,
    OP_PW_ON     = 3'd6,
    OP_NOP       = 3'd7
  } wbm_op_e;

  function automatic logic op_is_read(input logic [2:0] op);
    return (op == OP_RD_AT) || (op == OP_RD_ON);
  endfunction

  function automatic logic op_is_write(input logic [2:0] op);
    return (op == OP_WR_AT) || (op == OP_WR_ON) || (op == OP_PW_AT) || (op == OP_PW_ON);
  endfunction

  function automatic logic op_is_posted(input logic [2:0] op);
    return (op == OP_PW_AT) || (op == OP_PW_ON);
  endfunction

  function automatic logic op_continues(input logic [2:0] op);
    return (op == OP_WR_ON) || (op == OP_RD_ON) || (op == OP_PW_ON);
  endfunction

endpackage

// File: rtl/wbm_addr_track.sv
module wbm_addr_track #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_upd,
  input  logic          wr_upd,
  input  logic [AW-1:0] beat_addr,
  output logic [AW-1:0] last_rd,
  output logic [AW-1:0] last_wr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_rd <= '1;
      last_wr <= '1;
    end else begin
      if (rd_upd) last_rd <= beat_addr;
      if (wr_upd) last_wr <= beat_addr;
    end
  end

endmodule

// File: rtl/wbm_rst_pulse.sv
module wbm_rst_pulse #(
  parameter int RST_CYCLES = 2,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse,
  output logic busy
);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               remain_q <= '0;
    else if (start)           remain_q <= CW'(RST_CYCLES);
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign pulse = (remain_q != '0);
  assign busy  = pulse;

endmodule

// File: rtl/wbm_seq.sv
module wbm_seq
  import wbm_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DWO   = 32,
  parameter int DWI   = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DWO-1:0]   cmd_wdata,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             word_take,
  input  logic [AW-1:0]    last_rd,
  input  logic [AW-1:0]    last_wr,
  output logic             beat_rd,
  output logic             beat_wr,
  output logic [AW-1:0]    bus_addr,
  output logic [DWO-1:0]   bus_wdata,
  output logic             bus_we,
  output logic             bus_cyc,
  output logic             posted,
  input  logic             ack_i,
  input  logic [DWI-1:0]   dat_i,
  output logic             rd_valid,
  output logic [DWI-1:0]   rd_data,
  output logic             rst_start,
  input  logic             rst_busy
);

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_GAP} st_e;

  function automatic logic [AW-1:0] follow_on(input logic [AW-1:0] prev);
    return prev + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] words_of(input logic [CNT_W-1:0] n);
    return (n == '0) ? CNT_W'(1) : n;
  endfunction

  st_e              st_q;
  logic [AW-1:0]    addr_q;
  logic [DWO-1:0]   data_q;
  logic [CNT_W-1:0] remain_q;
  logic             is_rd_q;
  logic             posted_q;
  logic             rd_valid_q;
  logic [DWI-1:0]   rd_data_q;

  logic             accept;
  logic             bus_op;
  logic [AW-1:0]    base_addr;
  logic             beat;
  logic             last_beat;

  assign cmd_ready = (st_q == S_IDLE) && !rst_busy;
  assign accept    = cmd_valid && cmd_ready;
  assign bus_op    = op_is_read(cmd_op) || op_is_write(cmd_op);
  assign rst_start = accept && (cmd_op == OP_PULSE_RST);

  always_comb begin
    if (op_continues(cmd_op))
      base_addr = op_is_read(cmd_op) ? follow_on(last_rd) : follow_on(last_wr);
    else
      base_addr = cmd_addr;
  end

  assign beat      = (st_q == S_BUS) && (posted_q || ack_i);
  assign last_beat = (remain_q == CNT_W'(1));
  assign beat_rd   = beat && is_rd_q;
  assign beat_wr   = beat && !is_rd_q;

  assign word_take = (accept && op_is_write(cmd_op))
                   || ((st_q == S_BUS) && posted_q && !last_beat)
                   || ((st_q == S_GAP) && !is_rd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      remain_q   <= '0;
      is_rd_q    <= 1'b0;
      posted_q   <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= beat_rd;
      if (beat_rd) rd_data_q <= dat_i;
      unique case (st_q)
        S_IDLE: begin
          if (accept && bus_op) begin
            addr_q   <= base_addr;
            data_q   <= cmd_wdata;
            remain_q <= words_of(cmd_count);
            is_rd_q  <= op_is_read(cmd_op);
            posted_q <= op_is_posted(cmd_op);
            st_q     <= S_BUS;
          end
        end
        S_BUS: begin
          if (beat) begin
            if (last_beat) begin
              st_q     <= S_IDLE;
              posted_q <= 1'b0;
            end else begin
              remain_q <= remain_q - 1'b1;
              addr_q   <= follow_on(addr_q);
              if (posted_q) data_q <= cmd_wdata;
              else          st_q   <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (!is_rd_q) data_q <= cmd_wdata;
          st_q <= S_BUS;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign bus_addr  = addr_q;
  assign bus_wdata = data_q;
  assign bus_we    = (st_q == S_BUS) && !is_rd_q;
  assign bus_cyc   = (st_q == S_BUS);
  assign posted    = posted_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;

endmodule

// File: rtl/wb_cmd_master.sv
module wb_cmd_master #(
  parameter int ADDR_W     = 16,
  parameter int DATA_OUT_W = 32,
  parameter int DATA_IN_W  = 32,
  parameter int CNT_W      = 8,
  parameter int RST_CYCLES = 2,
  localparam int AWP  = (ADDR_W     > 0) ? ADDR_W     : 1,
  localparam int DWOP = (DATA_OUT_W > 0) ? DATA_OUT_W : 1,
  localparam int DWIP = (DATA_IN_W  > 0) ? DATA_IN_W  : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [AWP-1:0]   cmd_addr,
  input  logic [DWOP-1:0]  cmd_wdata,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             word_take,
  output logic             rd_valid,
  output logic [DWIP-1:0]  rd_data,
  output logic             wb_rst_o,
  output logic [AWP-1:0]   wb_adr_o,
  output logic [DWOP-1:0]  wb_dat_o,
  output logic             wb_we_o,
  input  logic [DWIP-1:0]  wb_dat_i,
  output logic             wb_stb_o,
  input  logic             wb_ack_i,
  output logic             wb_cyc_o
);

  logic [AWP-1:0]  last_rd, last_wr, seq_addr;
  logic [DWOP-1:0] seq_wdata;
  logic [DWIP-1:0] seq_din;
  logic            beat_rd, beat_wr, seq_we, seq_cyc, seq_posted;
  logic            rst_start, rst_busy;

  wbm_addr_track #(.AW(AWP)) track_i (
    .clk(clk), .rst_n(rst_n), .rd_upd(beat_rd), .wr_upd(beat_wr),
    .beat_addr(seq_addr), .last_rd(last_rd), .last_wr(last_wr)
  );

  wbm_rst_pulse #(.RST_CYCLES(RST_CYCLES)) pulse_i (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .pulse(wb_rst_o), .busy(rst_busy)
  );

  wbm_seq #(.AW(AWP), .DWO(DWOP), .DWI(DWIP), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_count(cmd_count),
    .word_take(word_take), .last_rd(last_rd), .last_wr(last_wr),
    .beat_rd(beat_rd), .beat_wr(beat_wr), .bus_addr(seq_addr), .bus_wdata(seq_wdata),
    .bus_we(seq_we), .bus_cyc(seq_cyc), .posted(seq_posted), .ack_i(wb_ack_i),
    .dat_i(seq_din), .rd_valid(rd_valid), .rd_data(rd_data),
    .rst_start(rst_start), .rst_busy(rst_busy)
  );

  generate
    if (ADDR_W > 0) begin : g_adr
      assign wb_adr_o = seq_addr;
    end else begin : g_no_adr
      assign wb_adr_o = '0;
    end
    if (DATA_OUT_W > 0) begin : g_dout
      assign wb_dat_o = seq_wdata;
      assign wb_we_o  = seq_we;
    end else begin : g_no_dout
      assign wb_dat_o = '0;
      assign wb_we_o  = 1'b0;
    end
    if (DATA_IN_W > 0) begin : g_din
      assign seq_din = wb_dat_i;
    end else begin : g_no_din
      assign seq_din = '0;
    end
  endgenerate

  assign wb_cyc_o = seq_cyc;
  assign wb_stb_o = seq_cyc;

endmodule

// File: rtl/wbm_check.sv
module wbm_check #(
  parameter int AWP        = 16,
  parameter int DWOP       = 32,
  parameter int RST_CYCLES = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cyc,
  input logic            ack,
  input logic [AWP-1:0]  adr,
  input logic [DWOP-1:0] dat,
  input logic            rst_pulse,
  input logic            ready,
  input logic            rvalid,
  input logic            posted
);

  logic [7:0] rst_len;

  always_ff @(posedge clk) begin
    if (!rst_n)         rst_len <= '0;
    else if (rst_pulse) rst_len <= rst_len + 1'b1;
    else                rst_len <= '0;
  end

  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && !ack && !posted) |=> (cyc && $stable(adr) && $stable(dat)));

  assert_gap_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && ack && !posted) |=> !cyc);

  assert_posted_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && posted) |=> (!cyc || (adr == ($past(adr) + 1'b1))));

  assert_rvalid_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  assert_ready_not_on_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !cyc);

  assert_pulse_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> (!cyc && !ready));

  assert_pulse_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pulse) |-> (rst_len == 8'(RST_CYCLES)));

endmodule

bind wb_cmd_master wbm_check #(.AWP(AWP), .DWOP(DWOP), .RST_CYCLES(RST_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc(wb_cyc_o), .ack(wb_ack_i), .adr(wb_adr_o),
  .dat(wb_dat_o), .rst_pulse(wb_rst_o), .ready(cmd_ready), .rvalid(rd_valid),
  .posted(seq_posted)
);

// File: tb/wb_cmd_master_tb_top.sv
module wb_cmd_master_tb_top;

  localparam int RSTC = 2;
  localparam int NV   = 16;

  // op, addr, count, data base, slave latency
  localparam int V_OP  [NV] = '{4, 1, 2, 1, 2, 3, 4, 5, 6, 3, 0, 2, 4, 7, 6, 3};
  localparam int V_AD  [NV] = '{0, 4, 0, 10, 0, 4, 0, 20, 0, 20, 0, 0, 0, 0, 0, 26};
  localparam int V_N   [NV] = '{1, 1, 1, 3, 2, 2, 1, 4, 1, 5, 0, 1, 0, 1, 2, 2};
  localparam int V_D   [NV] = '{0, 'h100, 'h200, 'h300, 'h400, 0, 0, 'h500, 'h600, 0, 0,
                                'h700, 0, 0, 'h800, 0};
  localparam int V_L   [NV] = '{0, 0, 1, 2, 0, 1, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_addr = '0;
  logic [31:0] cmd_wdata;
  logic [7:0]  cmd_count = '0;
  logic        word_take, rd_valid;
  logic [31:0] rd_data;
  logic        wb_rst_o, wb_we_o, wb_stb_o, wb_cyc_o;
  logic        wb_ack_i = 1'b0;
  logic [15:0] wb_adr_o;
  logic [31:0] wb_dat_o, wb_dat_i;

  int vectors = 0, miscompares = 0;
  int cyc_cnt, rise_cnt, rsthi_cnt, rcnt, lat_err;
  bit cyc_prev = 0, ack_prev = 0, take_n = 0;
  logic [31:0] rdbuf [16];
  logic [31:0] mem [64];
  logic [31:0] mirror [64];
  int slave_lat = 0, wc = 0;
  int take_total = 0, take_start = 0;
  logic [31:0] wbase = '0;
  int busy;
  logic [15:0] m_last_wr, m_last_rd;

  wb_cmd_master #(.ADDR_W(16), .DATA_OUT_W(32), .DATA_IN_W(32), .CNT_W(8), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_count(cmd_count), .word_take(word_take),
    .rd_valid(rd_valid), .rd_data(rd_data), .wb_rst_o(wb_rst_o), .wb_adr_o(wb_adr_o),
    .wb_dat_o(wb_dat_o), .wb_we_o(wb_we_o), .wb_dat_i(wb_dat_i), .wb_stb_o(wb_stb_o),
    .wb_ack_i(wb_ack_i), .wb_cyc_o(wb_cyc_o)
  );

  always #4 clk = ~clk;

  // slave: writes on every strobed write clock, acks after slave_lat waiting clocks
  assign wb_dat_i = mem[wb_adr_o[5:0]];
  always @(posedge clk) begin
    if (wb_cyc_o && wb_stb_o && wb_we_o) mem[wb_adr_o[5:0]] <= wb_dat_o;
    if (wb_cyc_o && wb_stb_o && !wb_ack_i) begin
      if (wc == slave_lat) begin wb_ack_i <= 1'b1; wc <= 0; end
      else wc <= wc + 1;
    end else begin
      wb_ack_i <= 1'b0;
      if (!wb_cyc_o) wc <= 0;
    end
    if (take_n) take_total <= take_total + 1;
  end

  assign cmd_wdata = wbase + 32'(take_total - take_start);

  always @(negedge clk) begin
    if (wb_cyc_o) cyc_cnt++;
    if (wb_cyc_o && !cyc_prev) rise_cnt++;
    cyc_prev = wb_cyc_o;
    if (wb_rst_o) rsthi_cnt++;
    if (rd_valid) begin
      if (rcnt < 16) rdbuf[rcnt] = rd_data;
      rcnt++;
      if (!ack_prev) lat_err++;
    end
    ack_prev = wb_cyc_o && wb_ack_i && !wb_we_o;
    take_n = word_take;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input int op, input int ad, input int n, input int d, input int lat);
    @(negedge clk);
    cyc_cnt = 0; rise_cnt = 0; rsthi_cnt = 0; rcnt = 0; lat_err = 0;
    take_start = take_total; wbase = 32'(d); slave_lat = lat;
    cmd_op = 3'(op); cmd_addr = 16'(ad); cmd_count = 8'(n); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy = 0;
    while (!cmd_ready && busy < 2000) begin busy++; @(negedge clk); end
    repeat (2) @(negedge clk);
  endtask

  task automatic apply_and_check(input int op, input int ad, input int n, input int d, input int lat);
    int words;
    bit is_rd, is_wr, posted;
    logic [15:0] a0;
    words  = (n == 0) ? 1 : n;
    is_rd  = (op == 3) || (op == 4);
    is_wr  = (op == 1) || (op == 2) || (op == 5) || (op == 6);
    posted = (op == 5) || (op == 6);
    if (op == 2 || op == 6) a0 = m_last_wr + 16'd1;
    else if (op == 4)       a0 = m_last_rd + 16'd1;
    else                    a0 = 16'(ad);
    run_cmd(op, ad, n, d, lat);
    if (op == 0) begin
      check(busy == RSTC, "R10 ready low during pulse", busy, RSTC);
      check(rsthi_cnt == RSTC, "R10 pulse length", rsthi_cnt, RSTC);
      check(cyc_cnt == 0, "R10 no bus cycle in pulse", cyc_cnt, 0);
    end else if (op == 7) begin
      check(busy == 0 && cyc_cnt == 0, "R2 code 7 no activity", cyc_cnt + busy, 0);
    end else if (posted) begin
      check(busy == words, "R9 posted busy clocks", busy, words);
      check(cyc_cnt == words, "R7 one clock per posted word", cyc_cnt, words);
      check(rise_cnt == 1, "R7 back to back posted words", rise_cnt, 1);
    end else begin
      check(busy == words * (lat + 2) + words - 1, "R9 waited busy clocks", busy,
            words * (lat + 2) + words - 1);
      check(rise_cnt == words, "R6 one cycle start per word", rise_cnt, words);
    end
    if (is_wr) begin
      for (int k = 0; k < words; k++) begin
        mirror[6'(a0 + 16'(k))] = 32'(d + k);
        check(mem[6'(a0 + 16'(k))] == 32'(d + k), "R4 R3 written word", mem[6'(a0 + 16'(k))], d + k);
      end
      m_last_wr = a0 + 16'(words - 1);
    end
    if (is_rd) begin
      check(rcnt == words, "R8 read word count", rcnt, words);
      check(lat_err == 0, "R8 rd_valid one clock after ack", lat_err, 0);
      for (int k = 0; k < words && k < 16; k++)
        check(rdbuf[k] == mirror[6'(a0 + 16'(k))], "R3 R8 read word", rdbuf[k], mirror[6'(a0 + 16'(k))]);
      m_last_rd = a0 + 16'(words - 1);
    end else begin
      check(rcnt == 0, "R8 no rd_valid without read", rcnt, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = 32'hA000 + 32'(i); mirror[i] = 32'hA000 + 32'(i); end
    m_last_wr = 16'hFFFF; m_last_rd = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    check(wb_cyc_o == 0 && wb_stb_o == 0, "R1 bus idle after reset", wb_cyc_o, 0);
    check(wb_rst_o == 0 && rd_valid == 0 && word_take == 0, "R1 strobes low after reset",
          {wb_rst_o, rd_valid, word_take}, 0);

    for (int v = 0; v < NV; v++)
      apply_and_check(V_OP[v], V_AD[v], V_N[v], V_D[v], V_L[v]);

    // directed: hard reset returns the remembered write address to all ones (R1)
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    m_last_wr = 16'hFFFF; m_last_rd = 16'hFFFF;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1 ready after second reset", cmd_ready, 1);
    apply_and_check(2, 0, 1, 'h900, 1);
    check(mem[0] == 32'h900, "R1 first continuing write at address 0", mem[0], 32'h900);
    // directed: posted run with immediate acks ignored, then read back (R7)
    apply_and_check(5, 40, 6, 'hB00, 0);
    apply_and_check(3, 40, 6, 0, 2);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule